// File: doc/BRIEF.md
# Latched Driver Fault Supervisor

This block watches a stepping-motor power stage for three kinds of fault and shuts the stage down when one occurs. The faults are excess winding current, excess substrate temperature and a disconnected motor lead. Comparator flags for current and temperature arrive asynchronously. The lead check uses a flag that shows whether recirculating (flyback) current is flowing. The PWM controller supplies a strobe at the start of every chopping period and a strobe when the gate switches off inside that period. The block uses these strobes to time its checks.

A fault is held once it is seen. While any fault is held, every phase drive output is forced low, whatever the enable level. The block reports an active-low summary flag and a two-bit fault code, which a later stage turns into one of three analog levels. Held faults are released only by a power-on reset, or by the reset pin dropping low and then returning high. Whenever enable is low the drive outputs are off, no new fault is detected, and faults already held are kept.

Top module: `fault_latch_supervisor`

## Requirements
- R1: After power-on reset, faultN is 1, faultCode is 2'b00, and driveOut follows gateReq while enableIn is 1.
- R2: An overcurrent flag that reaches the end of its two-flop synchronizer outside the blanking window sets the overcurrent fault, reported as faultCode 2'b10.
- R3: The overcurrent flag is not evaluated on the clock edge that samples periodStart, nor on the following BLANK_CYCLES edges. A flag seen only inside that window has no effect.
- R4: An over-temperature flag seen after synchronization sets the over-temperature fault, reported as faultCode 2'b11.
- R5: If a period contained a gateOffStrobe and no flyback was seen during its off interval, the next periodStart sets the open-terminal fault, reported as faultCode 2'b01.
- R6: No open-terminal fault is set for a period in which flyback was seen during the off interval. None is set for a period that had no gateOffStrobe.
- R7: When several faults are held, faultCode shows the one with the highest priority. The order is over-temperature (11), then overcurrent (10), then open terminal (01).
- R8: faultN is 0 exactly when at least one fault is held.
- R9: driveOut is all zero while any fault is held or enableIn is 0.
- R10: A held fault stays held while the reset pin is low. It is cleared once the synchronized reset pin returns high after being low.
- R11: While enableIn is 0, no fault is set and held faults stay unchanged.
- R12: Asserting the power-on reset clears every held fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstPorN | input | 1 | Power-on reset, asynchronous, active low |
| rstPinIn | input | 1 | Reset pin level; a high-low-high sequence clears held faults |
| enableIn | input | 1 | Drive enable level |
| ocFlagIn | input | 1 | Overcurrent comparator flag, asynchronous |
| otFlagIn | input | 1 | Over-temperature flag, asynchronous |
| flybackIn | input | 1 | Flyback current present flag, asynchronous |
| periodStart | input | 1 | One-cycle strobe at the start of each PWM period |
| gateOffStrobe | input | 1 | One-cycle strobe when the gate turns off inside a period |
| gateReq | input | PHASES | Requested phase drive from the PWM logic |
| driveOut | output | PHASES | Gated phase drive |
| faultN | output | 1 | Summary fault flag, active low |
| faultCode | output | 2 | Prioritised fault type: 00 none, 01 open, 10 overcurrent, 11 over-temperature |

## Verification
The bound assertions run on every cycle. They check that faultN agrees with the code and that the drive is off while a fault is held. They also check that the code never drops without a reset-pin clear, that no overcurrent fault appears inside a blanking window, and that nothing changes while enable is low. Two behaviours depend on sequences of events, so only the bench scenarios show them. One is open-terminal inference, which needs a gate-off period with or without flyback. The other is clearing, which needs a full high-low-high reset-pin pulse. A reference model runs beside the random phase and compares the code, flag and drive on every cycle.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;

  typedef enum logic [1:0] {
    FC_NONE     = 2'b00,
    FC_OPEN     = 2'b01,
    FC_OVERCUR  = 2'b10,
    FC_OVERTEMP = 2'b11
  } faultCode_e;

  // Held fault bits, one per detector.
  typedef struct packed {
    logic overTemp;
    logic overCur;
    logic openTerm;
  } faultSet_t;

  // Strobes the timing control hands to the latch datapath.
  typedef struct packed {
    logic detectEn;     // detection allowed this cycle
    logic ocWindowOpen; // overcurrent may be sampled (blanking over)
    logic offWindow;    // inside off interval of a period that turned off
    logic evalOpen;     // period ends after a gate-off: judge flyback
    logic clearLatch;   // reset pin returned high
  } supStrobes_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RST_VAL;
    end else begin
      stageQ[0] <= dIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dOut = stageQ[STAGES-1];

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import fault_sup_pkg::*;
#(
  parameter int BLANK_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstPorN,
  input  logic        enableIn,
  input  logic        periodStart,
  input  logic        gateOffStrobe,
  input  logic        rstPinSync,
  output supStrobes_t strb
);

  localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [BLANK_W-1:0] BLANK_LOAD = BLANK_W'(BLANK_CYCLES);

  logic [BLANK_W-1:0] blankCnt;
  logic               offWin;
  logic               rstPinPrev;

  // Dead-time counter restarted by every period start.
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      blankCnt <= '0;
    end else if (periodStart) begin
      blankCnt <= BLANK_LOAD;
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - 1'b1;
    end
  end

  // Off interval: opened by a gate-off, closed by the next period or disable.
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      offWin <= 1'b0;
    end else if (periodStart || !enableIn) begin
      offWin <= 1'b0;
    end else if (gateOffStrobe) begin
      offWin <= 1'b1;
    end
  end

  // Reset pin history; reset value high so only a real low-then-high clears.
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) rstPinPrev <= 1'b1;
    else          rstPinPrev <= rstPinSync;
  end

  always_comb begin
    strb.detectEn     = enableIn;
    strb.ocWindowOpen = enableIn && !periodStart && (blankCnt == '0);
    strb.offWindow    = offWin;
    strb.evalOpen     = enableIn && periodStart && offWin;
    strb.clearLatch   = rstPinSync && !rstPinPrev;
  end

endmodule

// File: rtl/sup_latch.sv
module sup_latch
  import fault_sup_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  supStrobes_t       strb,
  input  logic              ocSync,
  input  logic              otSync,
  input  logic              fbSync,
  input  logic              enableIn,
  input  logic [PHASES-1:0] gateReq,
  output logic [PHASES-1:0] driveOut,
  output logic              faultN,
  output logic [1:0]        faultCode,
  output faultSet_t         heldFaults
);

  faultSet_t held;
  logic      fbSeen;
  logic      anyHeld;
  logic      driveAllowed;

  // Flyback memory for the current off interval.
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      fbSeen <= 1'b0;
    end else if (strb.evalOpen || !strb.offWindow) begin
      fbSeen <= 1'b0;
    end else if (fbSync) begin
      fbSeen <= 1'b1;
    end
  end

  // Fault latches: clear wins over a set on the same edge.
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      held <= '0;
    end else if (strb.clearLatch) begin
      held <= '0;
    end else begin
      if (strb.detectEn && otSync)         held.overTemp <= 1'b1;
      if (strb.ocWindowOpen && ocSync)     held.overCur  <= 1'b1;
      if (strb.evalOpen && !fbSeen)        held.openTerm <= 1'b1;
    end
  end

  always_comb begin
    anyHeld = held.overTemp | held.overCur | held.openTerm;
    if (held.overTemp)     faultCode = FC_OVERTEMP;
    else if (held.overCur) faultCode = FC_OVERCUR;
    else if (held.openTerm) faultCode = FC_OPEN;
    else                   faultCode = FC_NONE;
    faultN       = !anyHeld;
    driveAllowed = enableIn && !anyHeld;
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_drive
    assign driveOut[p] = gateReq[p] & driveAllowed;
  end

  assign heldFaults = held;

endmodule

// File: rtl/fault_latch_supervisor.sv
module fault_latch_supervisor
  import fault_sup_pkg::*;
#(
  parameter int PHASES       = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              rstPinIn,
  input  logic              enableIn,
  input  logic              ocFlagIn,
  input  logic              otFlagIn,
  input  logic              flybackIn,
  input  logic              periodStart,
  input  logic              gateOffStrobe,
  input  logic [PHASES-1:0] gateReq,
  output logic [PHASES-1:0] driveOut,
  output logic              faultN,
  output logic [1:0]        faultCode
);

  localparam int SYNC_W = 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = 4'b1000; // reset pin idles high

  logic [SYNC_W-1:0] rawIn;
  logic [SYNC_W-1:0] syncOut;
  supStrobes_t       strb;
  faultSet_t         heldFaults;

  assign rawIn = {rstPinIn, flybackIn, otFlagIn, ocFlagIn};

  sup_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rstN(rstPorN),
    .dIn (rawIn),
    .dOut(syncOut)
  );

  sup_ctrl #(
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rstPorN      (rstPorN),
    .enableIn     (enableIn),
    .periodStart  (periodStart),
    .gateOffStrobe(gateOffStrobe),
    .rstPinSync   (syncOut[3]),
    .strb         (strb)
  );

  sup_latch #(
    .PHASES(PHASES)
  ) u_latch (
    .clk       (clk),
    .rstPorN   (rstPorN),
    .strb      (strb),
    .ocSync    (syncOut[0]),
    .otSync    (syncOut[1]),
    .fbSync    (syncOut[2]),
    .enableIn  (enableIn),
    .gateReq   (gateReq),
    .driveOut  (driveOut),
    .faultN    (faultN),
    .faultCode (faultCode),
    .heldFaults(heldFaults)
  );

endmodule

// File: rtl/fault_sup_chk.sv
module fault_sup_chk
  import fault_sup_pkg::*;
#(
  parameter int PHASES       = 4,
  parameter int BLANK_CYCLES = 8
) (
  input logic              clk,
  input logic              rstPorN,
  input logic              enableIn,
  input logic              periodStart,
  input logic              faultN,
  input logic [1:0]        faultCode,
  input logic [PHASES-1:0] driveOut,
  input logic              clearLatch,
  input faultSet_t         heldFaults
);

  localparam int CW = $clog2(BLANK_CYCLES + 1);

  logic [CW-1:0] shadowCnt;

  // Independent count of the dead time after each period start.
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)           shadowCnt <= '0;
    else if (periodStart)   shadowCnt <= CW'(BLANK_CYCLES);
    else if (shadowCnt != 0) shadowCnt <= shadowCnt - 1'b1;
  end

  // R8
  flag_matches_code_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    faultN == (faultCode == 2'b00));

  // R7
  temp_wins_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    heldFaults.overTemp |-> faultCode == 2'b11);

  // R9
  drive_off_on_fault_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    !faultN |-> driveOut == '0);

  // R10
  fault_holds_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    (faultCode != 2'b00 && !clearLatch) |=> faultCode != 2'b00);

  // R3
  no_oc_in_blank_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    (periodStart || shadowCnt != 0) |=> !$rose(heldFaults.overCur));

  // R11
  frozen_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    (!enableIn && !clearLatch) |=> $stable(faultCode));

endmodule

bind fault_latch_supervisor fault_sup_chk #(
  .PHASES      (PHASES),
  .BLANK_CYCLES(BLANK_CYCLES)
) u_chk (
  .clk        (clk),
  .rstPorN    (rstPorN),
  .enableIn   (enableIn),
  .periodStart(periodStart),
  .faultN     (faultN),
  .faultCode  (faultCode),
  .driveOut   (driveOut),
  .clearLatch (strb.clearLatch),
  .heldFaults (heldFaults)
);

// File: tb/fault_latch_supervisor_bench.sv
module fault_latch_supervisor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;
  localparam int BLANK = 8;

  logic clk = 1'b0;
  logic porN = 1'b0, rstPin = 1'b1, en = 1'b1;
  logic oc = 1'b0, ot = 1'b0, fb = 1'b0, ps = 1'b0, go = 1'b0;
  logic [PH-1:0] gate = 4'b1010;
  logic [PH-1:0] driveOut;
  logic faultN;
  logic [1:0] faultCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_latch_supervisor #(.PHASES(PH), .SYNC_STAGES(2), .BLANK_CYCLES(BLANK))
    u_fault_latch_supervisor (
      .clk(clk), .rstPorN(porN), .rstPinIn(rstPin), .enableIn(en),
      .ocFlagIn(oc), .otFlagIn(ot), .flybackIn(fb), .periodStart(ps),
      .gateOffStrobe(go), .gateReq(gate), .driveOut(driveOut),
      .faultN(faultN), .faultCode(faultCode));

  // Reference model written from the requirements.
  logic mOc1, mOc2, mOt1, mOt2, mFb1, mFb2, mRp1, mRp2, mRpPrev;
  logic mWin, mFbSeen, mOpen, mOcL, mOtL;
  int   mCnt;

  function automatic logic [1:0] expCode(logic o, logic c, logic t);
    if (t) return 2'b11;
    if (c) return 2'b10;
    if (o) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [PH-1:0] expDrive(logic e, logic anyF, logic [PH-1:0] g);
    return (e && !anyF) ? g : '0;
  endfunction

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      {mOc1, mOc2, mOt1, mOt2, mFb1, mFb2} <= '0;
      {mRp1, mRp2, mRpPrev} <= 3'b111;
      mWin <= 0; mFbSeen <= 0; mOpen <= 0; mOcL <= 0; mOtL <= 0; mCnt <= 0;
    end else begin
      automatic logic clr   = mRp2 && !mRpPrev;
      automatic logic ocWin = en && !ps && (mCnt == 0);
      automatic logic evalO = en && ps && mWin;
      mOc1 <= oc; mOc2 <= mOc1; mOt1 <= ot; mOt2 <= mOt1;
      mFb1 <= fb; mFb2 <= mFb1; mRp1 <= rstPin; mRp2 <= mRp1; mRpPrev <= mRp2;
      mCnt <= ps ? BLANK : (mCnt != 0 ? mCnt - 1 : 0);
      mWin <= (ps || !en) ? 1'b0 : (go ? 1'b1 : mWin);
      mFbSeen <= (evalO || !mWin) ? 1'b0 : (mFb2 ? 1'b1 : mFbSeen);
      if (clr) begin
        mOpen <= 0; mOcL <= 0; mOtL <= 0;
      end else begin
        if (en && mOt2)      mOtL <= 1;
        if (ocWin && mOc2)   mOcL <= 1;
        if (evalO && !mFbSeen) mOpen <= 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (porN && !done) begin
      automatic logic [1:0] ec = expCode(mOpen, mOcL, mOtL);
      automatic logic anyF = mOpen | mOcL | mOtL;
      chk(faultCode == ec, "R7 code vs model", faultCode, ec);
      chk(faultN == !anyF, "R8 flag vs model", faultN, !anyF);
      chk(driveOut == expDrive(en, anyF, gate), "R9 drive vs model",
          driveOut, expDrive(en, anyF, gate));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePs();
    ps = 1; cyc(1); ps = 0;
  endtask

  task automatic pulseGo();
    go = 1; cyc(1); go = 0;
  endtask

  task automatic pinClear();
    rstPin = 0; cyc(3); rstPin = 1; cyc(5);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    fb = 1;
    cyc(4);
    porN = 1;
    cyc(2);
    // R1 reset state
    chk(faultN == 1, "R1 faultN after reset", faultN, 1);
    chk(faultCode == 2'b00, "R1 code after reset", faultCode, 0);
    chk(driveOut == gate, "R1 drive follows request", driveOut, gate);

    // R2 overcurrent outside blanking
    oc = 1; cyc(2); oc = 0; cyc(4);
    chk(faultCode == 2'b10, "R2 overcurrent code", faultCode, 2'b10);
    chk(faultN == 0, "R8 flag low on fault", faultN, 0);
    chk(driveOut == '0, "R9 drive forced off", driveOut, 0);

    // R10 hold through low pin, clear on return high
    cyc(10);
    rstPin = 0; cyc(4);
    chk(faultCode == 2'b10, "R10 held while pin low", faultCode, 2'b10);
    rstPin = 1; cyc(5);
    chk(faultCode == 2'b00, "R10 cleared after pin high", faultCode, 0);
    chk(driveOut == gate, "R10 drive restored", driveOut, gate);

    // R4 and R7 priority over overcurrent
    ot = 1; cyc(2); ot = 0; cyc(4);
    chk(faultCode == 2'b11, "R4 over-temp code", faultCode, 2'b11);
    oc = 1; cyc(2); oc = 0; cyc(4);
    chk(faultCode == 2'b11, "R7 over-temp beats overcurrent", faultCode, 2'b11);
    pinClear();

    // R3 blanking window
    pulsePs();
    oc = 1; cyc(3); oc = 0; cyc(12);
    chk(faultCode == 2'b00, "R3 overcurrent blanked", faultCode, 0);
    oc = 1; cyc(2); oc = 0; cyc(4);
    chk(faultCode == 2'b10, "R3 overcurrent after blank", faultCode, 2'b10);
    pinClear();

    // R5 open terminal: gate off and no flyback
    fb = 0;
    pulsePs(); cyc(2); pulseGo(); cyc(6); pulsePs(); cyc(2);
    chk(faultCode == 2'b01, "R5 open terminal code", faultCode, 2'b01);
    pinClear();

    // R6 flyback present, and period without gate-off
    pulsePs(); cyc(1); pulseGo(); fb = 1; cyc(3); fb = 0; cyc(4); pulsePs(); cyc(2);
    chk(faultCode == 2'b00, "R6 flyback seen no fault", faultCode, 0);
    cyc(6); pulsePs(); cyc(3);
    chk(faultCode == 2'b00, "R6 no gate-off no fault", faultCode, 0);

    // R7 overcurrent beats open
    pulseGo(); cyc(6); pulsePs(); cyc(2);
    chk(faultCode == 2'b01, "R5 open before overcurrent", faultCode, 2'b01);
    cyc(12); oc = 1; cyc(2); oc = 0; cyc(4);
    chk(faultCode == 2'b10, "R7 overcurrent beats open", faultCode, 2'b10);
    fb = 1;
    pinClear();

    // R11 disabled: nothing latches, drive off
    en = 0; cyc(1);
    chk(driveOut == '0, "R9 drive off when disabled", driveOut, 0);
    oc = 1; ot = 1; cyc(3); oc = 0; ot = 0; cyc(4);
    chk(faultCode == 2'b00, "R11 no detection when disabled", faultCode, 0);
    en = 1; cyc(2);
    chk(faultCode == 2'b00, "R11 still clear after enable", faultCode, 0);
    chk(driveOut == gate, "R11 drive back on", driveOut, gate);

    // R12 power-on reset clears
    ot = 1; cyc(2); ot = 0; cyc(4);
    chk(faultCode == 2'b11, "R12 fault before reset", faultCode, 2'b11);
    porN = 0; cyc(2); porN = 1; cyc(2);
    chk(faultCode == 2'b00, "R12 cleared by power-on reset", faultCode, 0);

    // Random phase, compared against the model every cycle.
    begin
      int perLen = 16, perPos = 0, goAt = 6;
      bit noFb = 0;
      for (int i = 0; i < 6000; i++) begin
        gate = PH'($urandom);
        ps = (perPos == 0);
        go = (perPos == goAt);
        fb = noFb ? 1'b0 : ($urandom % 4 != 0);
        oc = ($urandom % 300 == 0);
        ot = ($urandom % 1500 == 0);
        if ($urandom % 400 == 0) en = ~en;
        else if (!en && $urandom % 40 == 0) en = 1;
        rstPin = !($urandom % 150 == 0);
        perPos++;
        if (perPos >= perLen) begin
          perPos = 0;
          perLen = 12 + int'($urandom % 13);
          goAt = ($urandom % 4 == 0) ? perLen + 1 : 3 + int'($urandom % 6);
          noFb = ($urandom % 15 == 0);
        end
        cyc(1);
      end
    end
    ps = 0; go = 0; oc = 0; ot = 0; rstPin = 1;
    cyc(3);
    finishRun();
  end

endmodule